// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Break Generation

This block turns bytes taken from a transmit FIFO outside the block into asynchronous serial frames on a single line. Each frame has a low start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit and a stop period. All timing comes from an oversample tick that a baud generator outside the block supplies, 16 ticks per bit. The frame format is captured when the block takes a byte from the FIFO, so the format can be changed between frames without corrupting a frame already on the line.

The block has three ways to control the line apart from normal data. A static break input forces the line low and leaves the frame sequencer running. A one-shot LIN break sends a low field of programmable length and clears its own busy flag when the field ends. With hardware flow control turned on, a synchronised clear-to-send input of selectable polarity must be active before a new frame may start. Two status flags report progress: one when the FIFO has handed over its last byte, and one when the line has gone fully quiet.

Top module: `sertx_top`

## Requirements
- R1: A frame is a start bit of 0, then 5 + `wlen` data bits (`wlen` = 0..3) sent least significant bit first, then the optional parity bit, then the stop period at level 1. The line idles at 1.
- R2: When `par_en` = 1, a parity bit follows the last data bit. With `par_stick` = 0, the parity bit makes the number of ones across the data and parity bits even when `par_even` = 1 and odd when `par_even` = 0. With `par_stick` = 1, the parity bit is the constant value ~`par_even`.
- R3: The stop period lasts 16 ticks when `stop2` = 0. When `stop2` = 1 it lasts 32 ticks, except for 5-bit words, where it lasts 24 ticks (one and a half bits).
- R4: Each start, data and parity bit lasts 16 ticks. A byte waiting in the FIFO starts its frame straight after the stop period of the previous frame, so a frame of L ticks placed back-to-back gives start-to-start spacing of 2L to 2L+2 clock cycles when one tick arrives every second clock.
- R5: While `brk_force` = 1, `txd` is 0. Frames keep being sequenced underneath and finish on their normal schedule. After `brk_force` is released, `txd` returns to the level the sequencer is driving (1 when idle).
- R6: When `cts_auto` = 1, a frame starts only if the CTS input, after a two-flop synchroniser, equals `cts_pol`. The level is checked only at frame start, so a change of CTS during a frame never shortens that frame.
- R7: `tx_empty` is 1 only when the FIFO is empty and no frame or break field is being sent. It rises within 2 cycles after the last stop period ends and falls within 2 cycles after data becomes pending.
- R8: `hold_empty` resets to 1. It is set when a byte is taken and the FIFO is then empty. A `fifo_wr` pulse clears it on the next clock edge.
- R9: A pulse on `lin_go` sets `lin_busy`. Once no frame is in progress, the line is driven low for (`lin_cnt` + 2) × 16 ticks, and then `lin_busy` clears itself.
- R10: While `rst` is high and after it is released, `txd` = 1, `tx_empty` = 1, `hold_empty` = 1, `fifo_pop` = 0 and `lin_busy` = 0.
- R11: `fifo_pop` is a single-cycle pulse per byte. It is raised only when the FIFO was not empty in the cycle before, and never in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversample tick, 16 per bit time |
| fifo_data | input | 8 | Byte at the head of the transmit FIFO |
| fifo_empty | input | 1 | Transmit FIFO holds no byte |
| fifo_wr | input | 1 | Strobe: a byte was written into the FIFO |
| fifo_pop | output | 1 | Strobe: head byte taken, FIFO advances |
| wlen | input | 2 | Word length code, bits = 5 + code |
| stop2 | input | 1 | Long stop period (2 bits, or 1.5 for 5-bit words) |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Even parity / stick value select |
| par_stick | input | 1 | Stick parity |
| brk_force | input | 1 | Hold the line low |
| cts_auto | input | 1 | Gate frame start on CTS |
| cts_pol | input | 1 | Active CTS level |
| cts_pin | input | 1 | Asynchronous clear-to-send input |
| lin_go | input | 1 | Request a LIN break field |
| lin_cnt | input | 4 | LIN break length minus 2, in bit times |
| txd | output | 1 | Serial output line |
| tx_empty | output | 1 | FIFO empty and line quiet |
| hold_empty | output | 1 | Last FIFO byte handed to the shifter |
| lin_busy | output | 1 | LIN break pending or in progress |

## Verification
The overlap that matters most is a line override falling inside a frame. A forced break, a CTS drop or a new FIFO write can each arrive while the sequencer is part way through a frame. The bench provokes each one in the middle of a frame and judges it by time and by the FIFO read position. After a break held over a whole frame, the rise of `tx_empty` must still come within a few cycles of the frame's nominal length. After a CTS drop, the frame in flight must decode correctly, and the next queued byte must stay unread until CTS returns. A write that lands while the last byte is being shifted must clear `hold_empty` while `tx_empty` is still low.

// File: rtl/sertx_pkg.sv
`timescale 1ns/1ps
package sertx_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_LIN
  } tx_state_e;

  typedef struct packed {
    logic [1:0] wlen;
    logic       stop2;
    logic       par_en;
    logic       par_even;
    logic       par_stick;
  } frame_cfg_t;

  // parity bit for a byte under a given frame format
  function automatic logic calc_parity(input logic [BYTE_W-1:0] d,
                                       input frame_cfg_t c);
    logic [BYTE_W-1:0] mask;
    mask = BYTE_W'((1 << (5 + int'(c.wlen))) - 1);
    if (c.par_stick) return ~c.par_even;
    return c.par_even ? ^(d & mask) : ~^(d & mask);
  endfunction

endpackage

// File: rtl/sertx_cts_sync.sv
`timescale 1ns/1ps
module sertx_cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) chain <= rst ? '0 : async_in;
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], async_in};
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/sertx_engine.sv
`timescale 1ns/1ps
module sertx_engine
  import sertx_pkg::*;
#(
  parameter int OS_RATE = 16,
  parameter int LCW     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              os_tick,
  input  logic [BYTE_W-1:0] fifo_data,
  input  logic              fifo_empty,
  input  frame_cfg_t        cfg,
  input  logic              cts_auto,
  input  logic              cts_ok,
  input  logic              lin_go,
  input  logic [LCW-1:0]    lin_cnt,
  output logic              line,
  output logic              fifo_pop,
  output logic              eng_idle,
  output logic              lin_busy
);
  localparam int LIN_MAX = ((1 << LCW) + 1) * OS_RATE;
  localparam int TCW     = $clog2(LIN_MAX + 1);
  localparam int BCW     = $clog2(BYTE_W);
  localparam int HALF    = OS_RATE / 2;

  tx_state_e         state;
  logic [TCW-1:0]    tcnt, lim, lin_len, stop_lim;
  logic [BCW-1:0]    bidx, last_idx;
  logic [BYTE_W-1:0] shreg;
  frame_cfg_t        fcfg;
  logic              par_bit, pop_q, lin_q, tick_last;

  assign stop_lim = !fcfg.stop2        ? TCW'(OS_RATE) :
                    (fcfg.wlen == 2'd0) ? TCW'(OS_RATE + HALF) :
                                          TCW'(2 * OS_RATE);
  assign last_idx = BCW'(4) + BCW'(fcfg.wlen);

  always_comb begin
    case (state)
      ST_STOP: lim = stop_lim;
      ST_LIN:  lim = lin_len;
      default: lim = TCW'(OS_RATE);
    endcase
  end

  assign tick_last = os_tick && (tcnt == lim - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      tcnt    <= '0;
      bidx    <= '0;
      shreg   <= '0;
      fcfg    <= '0;
      par_bit <= 1'b0;
      lin_len <= '0;
      pop_q   <= 1'b0;
      lin_q   <= 1'b0;
    end else begin
      pop_q <= 1'b0;
      if (state == ST_IDLE) begin
        tcnt <= '0;
        if (lin_q) begin
          lin_len <= TCW'((int'(lin_cnt) + 2) * OS_RATE);
          state   <= ST_LIN;
        end else if (!fifo_empty && (!cts_auto || cts_ok)) begin
          pop_q   <= 1'b1;
          shreg   <= fifo_data;
          fcfg    <= cfg;
          par_bit <= calc_parity(fifo_data, cfg);
          state   <= ST_START;
        end
      end else if (os_tick) begin
        if (!tick_last) begin
          tcnt <= tcnt + 1'b1;
        end else begin
          tcnt <= '0;
          case (state)
            ST_START: begin
              bidx  <= '0;
              state <= ST_DATA;
            end
            ST_DATA: begin
              shreg <= shreg >> 1;
              if (bidx == last_idx) state <= fcfg.par_en ? ST_PAR : ST_STOP;
              else                  bidx  <= bidx + 1'b1;
            end
            ST_PAR:  state <= ST_STOP;
            ST_STOP: state <= ST_IDLE;
            ST_LIN: begin
              state <= ST_IDLE;
              lin_q <= 1'b0;
            end
            default: state <= ST_IDLE;
          endcase
        end
      end
      if (lin_go) lin_q <= 1'b1;
    end
  end

  always_comb begin
    case (state)
      ST_START: line = 1'b0;
      ST_DATA:  line = shreg[0];
      ST_PAR:   line = par_bit;
      ST_LIN:   line = 1'b0;
      default:  line = 1'b1;
    endcase
  end

  assign fifo_pop = pop_q;
  assign eng_idle = (state == ST_IDLE);
  assign lin_busy = lin_q;

  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> $past(!fifo_empty)); // R11
  AST_POP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |=> !fifo_pop); // R11
  AST_CTS_GATE: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> $past(!cts_auto || cts_ok)); // R6
  AST_LIN_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(lin_busy) |-> eng_idle); // R9
endmodule

// File: rtl/sertx_status.sv
`timescale 1ns/1ps
module sertx_status (
  input  logic clk,
  input  logic rst,
  input  logic fifo_empty,
  input  logic fifo_wr,
  input  logic fifo_pop,
  input  logic eng_idle,
  output logic tx_empty,
  output logic hold_empty
);
  logic te_q, he_q, pop_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      te_q  <= 1'b1;
      he_q  <= 1'b1;
      pop_d <= 1'b0;
    end else begin
      te_q  <= fifo_empty && eng_idle;
      pop_d <= fifo_pop;
      if (fifo_wr)                  he_q <= 1'b0;
      else if (pop_d && fifo_empty) he_q <= 1'b1;
    end
  end

  assign tx_empty   = te_q;
  assign hold_empty = he_q;

  AST_TE_FIFO_EMPTY: assert property (@(posedge clk) disable iff (rst)
    tx_empty && !$past(rst) |-> $past(fifo_empty)); // R7
  AST_HOLD_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(fifo_wr) && !$past(rst) |-> !hold_empty); // R8
endmodule

// File: rtl/sertx_top.sv
`timescale 1ns/1ps
module sertx_top
  import sertx_pkg::*;
#(
  parameter int OS_RATE    = 16,
  parameter int LCW        = 4,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              os_tick,
  input  logic [BYTE_W-1:0] fifo_data,
  input  logic              fifo_empty,
  input  logic              fifo_wr,
  output logic              fifo_pop,
  input  logic [1:0]        wlen,
  input  logic              stop2,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              par_stick,
  input  logic              brk_force,
  input  logic              cts_auto,
  input  logic              cts_pol,
  input  logic              cts_pin,
  input  logic              lin_go,
  input  logic [LCW-1:0]    lin_cnt,
  output logic              txd,
  output logic              tx_empty,
  output logic              hold_empty,
  output logic              lin_busy
);
  frame_cfg_t cfg;
  logic       cts_s, eng_line, eng_idle, txd_q;

  assign cfg = '{wlen: wlen, stop2: stop2, par_en: par_en,
                 par_even: par_even, par_stick: par_stick};

  sertx_cts_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst(rst), .async_in(cts_pin), .sync_out(cts_s));

  sertx_engine #(.OS_RATE(OS_RATE), .LCW(LCW)) u_eng (
    .clk(clk), .rst(rst), .os_tick(os_tick), .fifo_data(fifo_data),
    .fifo_empty(fifo_empty), .cfg(cfg), .cts_auto(cts_auto),
    .cts_ok(cts_s == cts_pol), .lin_go(lin_go), .lin_cnt(lin_cnt),
    .line(eng_line), .fifo_pop(fifo_pop), .eng_idle(eng_idle),
    .lin_busy(lin_busy));

  sertx_status u_stat (
    .clk(clk), .rst(rst), .fifo_empty(fifo_empty), .fifo_wr(fifo_wr),
    .fifo_pop(fifo_pop), .eng_idle(eng_idle), .tx_empty(tx_empty),
    .hold_empty(hold_empty));

  always_ff @(posedge clk) begin
    if (rst)            txd_q <= 1'b1;
    else if (brk_force) txd_q <= 1'b0;
    else                txd_q <= eng_line;
  end
  assign txd = txd_q;

  AST_BRK_LOW: assert property (@(posedge clk) disable iff (rst)
    $past(brk_force) && !$past(rst) |-> !txd); // R5
  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (rst)
    tx_empty && !$past(brk_force) && !$past(rst) && !$past(lin_busy) |-> txd); // R7
endmodule

// File: tb/sertx_top_test.sv
`timescale 1ns/1ps
module sertx_top_test;
  localparam int TP = 2;

  logic clk = 0, rst = 1, os_tick = 0;
  logic [7:0] fifo_data;
  logic fifo_empty, fifo_wr = 0, fifo_pop;
  logic [1:0] wlen = 0;
  logic stop2 = 0, par_en = 0, par_even = 0, par_stick = 0;
  logic brk_force = 0, cts_auto = 0, cts_pol = 0, cts_pin = 0, lin_go = 0;
  logic [3:0] lin_cnt = 0;
  logic txd, tx_empty, hold_empty, lin_busy;

  logic [7:0] fq [0:63];
  int wp = 0, rp = 0, mon_idx = 0, cyc = 0, nchk = 0, nfail = 0, nst = 0;
  int starts [0:255];
  bit mon_en = 1;

  always #2.5 clk = ~clk;

  sertx_top uut (.clk(clk), .rst(rst), .os_tick(os_tick), .fifo_data(fifo_data),
    .fifo_empty(fifo_empty), .fifo_wr(fifo_wr), .fifo_pop(fifo_pop), .wlen(wlen),
    .stop2(stop2), .par_en(par_en), .par_even(par_even), .par_stick(par_stick),
    .brk_force(brk_force), .cts_auto(cts_auto), .cts_pol(cts_pol), .cts_pin(cts_pin),
    .lin_go(lin_go), .lin_cnt(lin_cnt), .txd(txd), .tx_empty(tx_empty),
    .hold_empty(hold_empty), .lin_busy(lin_busy));

  assign fifo_empty = (wp == rp);
  assign fifo_data  = fq[rp % 64];

  always @(posedge clk) begin
    cyc++;
    os_tick <= rst ? 1'b0 : ~os_tick;
    if (fifo_pop) rp <= rp + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_par(input logic [7:0] d);
    logic [7:0] m;
    m = 8'((1 << (5 + int'(wlen))) - 1);
    if (par_stick) return ~par_even;
    return par_even ? ^(d & m) : ~^(d & m);
  endfunction

  task automatic nwait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    fq[wp % 64] = d;
    wp = wp + 1;
    fifo_wr = 1;
    @(negedge clk);
    fifo_wr = 0;
  endtask

  task automatic wait_quiet();
    int n = 0;
    nwait(3);
    while (!tx_empty && n < 20000) begin nwait(1); n++; end
  endtask

  // serial receiver model: checks one frame per start edge (R1 R2 R3)
  task automatic rx_frame();
    logic [7:0] got_d, ed;
    logic gp, ep, s1, s2;
    int nb;
    nb = 5 + int'(wlen);
    got_d = 0; gp = 0; ep = 0; s2 = 1;
    nwait(8 * TP);
    if (txd !== 1'b0) got_d = 8'hEE;
    for (int k = 0; k < nb; k++) begin
      nwait(16 * TP);
      got_d[k] = txd;
    end
    if (par_en) begin nwait(16 * TP); gp = txd; end
    nwait(16 * TP);
    s1 = txd;
    if (stop2) begin
      nwait(wlen == 0 ? 12 * TP : 16 * TP);
      s2 = txd;
    end
    ed = fq[mon_idx % 64] & 8'((1 << nb) - 1);
    if (par_en) ep = exp_par(fq[mon_idx % 64]);
    chk({s1, s2, gp, got_d} == {2'b11, ep, ed}, "R1 R2 R3 frame decode",
        int'({s1, s2, gp, got_d}), int'({2'b11, ep, ed}));
    mon_idx++;
  endtask

  always begin
    @(negedge txd);
    if (mon_en && !rst) begin
      if (nst < 256) starts[nst] = cyc;
      nst++;
      rx_frame();
    end
  end

  task automatic set_cfg(input logic [1:0] w, input logic s2, input logic pe,
                         input logic ev, input logic st);
    wlen = w; stop2 = s2; par_en = pe; par_even = ev; par_stick = st;
  endtask

  task automatic spacing(input int L, input string tag);
    int d;
    d = starts[nst - 1] - starts[nst - 2];
    chk(d >= 2 * L && d <= 2 * L + 2, tag, d, 2 * L);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin : main
    int t0, d, base;
    void'($urandom(32'h1234_5eed));
    repeat (5) @(posedge clk);
    chk(txd && tx_empty && hold_empty && !fifo_pop && !lin_busy, "R10 in reset",
        int'({txd, tx_empty, hold_empty, fifo_pop, lin_busy}), 'h1C);
    @(negedge clk); rst = 0;
    nwait(4);
    chk(txd && tx_empty && hold_empty && !fifo_pop && !lin_busy, "R10 after reset",
        int'({txd, tx_empty, hold_empty, fifo_pop, lin_busy}), 'h1C);

    // directed and random format bursts (R1 R2 R3 R11)
    for (int b = 0; b < 10; b++) begin
      case (b)
        0: set_cfg(2'd3, 0, 1, 0, 1);
        1: set_cfg(2'd3, 1, 1, 1, 1);
        2: set_cfg(2'd0, 1, 0, 0, 0);
        3: set_cfg(2'd1, 1, 1, 1, 0);
        default: set_cfg(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      endcase
      base = rp;
      for (int i = 0; i < 5; i++) push(8'($urandom));
      wait_quiet();
      chk(rp == base + 5, "R11 one pop per byte", rp - base, 5);
    end

    // back-to-back spacing (R3 R4)
    set_cfg(2'd0, 1, 0, 0, 0);
    push(8'h15); push(8'h0A); wait_quiet();
    spacing(16 * 6 + 24, "R3 1.5 stop spacing");
    set_cfg(2'd1, 1, 0, 0, 0);
    push(8'h2C); push(8'h13); wait_quiet();
    spacing(16 * 7 + 32, "R3 2 stop spacing");
    set_cfg(2'd3, 0, 1, 1, 0);
    push(8'hA5); push(8'h5A); wait_quiet();
    spacing(16 * 10 + 16, "R4 bit time spacing");

    // tx_empty timing (R7)
    set_cfg(2'd3, 0, 0, 0, 0);
    push(8'hC3);
    nwait(1);
    chk(!tx_empty, "R7 falls when pending", tx_empty, 0);
    while (!tx_empty) nwait(1);
    d = cyc - starts[nst - 1];
    chk(d >= 318 && d <= 323, "R7 rise after stop", d, 320);

    // holding-empty flag (R8)
    push(8'h81);
    chk(!hold_empty, "R8 cleared by write", hold_empty, 0);
    nwait(8);
    chk(hold_empty && !tx_empty, "R8 set on last pop", int'({hold_empty, tx_empty}), 2);
    push(8'h7E);
    chk(!hold_empty, "R8 write mid frame", hold_empty, 0);
    wait_quiet();
    chk(hold_empty, "R8 set after final pop", hold_empty, 1);

    // static break (R5)
    mon_en = 0;
    @(negedge clk); brk_force = 1;
    nwait(3);
    chk(!txd, "R5 idle break low", txd, 0);
    @(negedge clk); brk_force = 0;
    nwait(3);
    chk(txd, "R5 release to mark", txd, 1);
    @(negedge clk); brk_force = 1;
    push(8'h55);
    t0 = cyc;
    nwait(100);
    chk(!txd && !tx_empty, "R5 low over busy frame", int'({txd, tx_empty}), 0);
    while (!tx_empty) nwait(1);
    d = cyc - t0;
    chk(d >= 318 && d <= 330, "R5 sequencing kept", d, 322);
    mon_idx++;
    @(negedge clk); brk_force = 0;
    nwait(3);
    chk(txd, "R5 mark after release", txd, 1);

    // LIN break fields (R9)
    for (int j = 0; j < 2; j++) begin
      lin_cnt = (j == 0) ? 4'd3 : 4'd15;
      @(negedge clk); lin_go = 1;
      @(negedge clk); lin_go = 0;
      while (txd) nwait(1);
      t0 = cyc;
      chk(lin_busy, "R9 busy during field", lin_busy, 1);
      while (!txd) nwait(1);
      d = cyc - t0;
      chk(d >= 2 * 16 * (lin_cnt + 2) - 2 && d <= 2 * 16 * (lin_cnt + 2) + 2,
          "R9 field length", d, 2 * 16 * (lin_cnt + 2));
      nwait(3);
      chk(!lin_busy && tx_empty, "R9 self clear", int'({lin_busy, tx_empty}), 1);
    end
    mon_en = 1;

    // CTS flow control (R6)
    cts_auto = 1; cts_pol = 1; cts_pin = 0;
    base = rp;
    push(8'h3C);
    nwait(200);
    chk(rp == base && !tx_empty && txd, "R6 blocked high pol", rp - base, 0);
    cts_pin = 1;
    wait_quiet();
    chk(rp == base + 1, "R6 released", rp - base, 1);
    push(8'h96); push(8'h69);
    while (rp == base + 1) nwait(1);
    nwait(100);
    cts_pin = 0;
    nwait(600);
    chk(rp == base + 2 && mon_idx == base + 2, "R6 no truncation, next held",
        rp - base, 2);
    cts_pin = 1;
    wait_quiet();
    chk(rp == base + 3, "R6 resumes", rp - base, 3);
    cts_pol = 0; cts_pin = 1;
    push(8'hF0);
    nwait(200);
    chk(rp == base + 3, "R6 blocked low pol", rp - base, 3);
    cts_pin = 0;
    wait_quiet();
    chk(rp == base + 4 && mon_idx == rp, "R6 low pol released", rp - base, 4);
    cts_auto = 0;

    nwait(20);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule